// File: doc/BRIEF.md
# Packed Lane Narrowing and Interleave Unit

This block rearranges the lanes of two 64-bit operands, A and B, into one 64-bit result. It can narrow packed lanes to half their width with saturation, or it can interleave lanes taken from the same half (lower or upper 32 bits) of both operands. A 4-bit operation code picks one of nine operations. Any other code yields a zero result.

A caller presents A, B and the code together with a valid strobe. One clock edge later the unit shows the registered result and a matching valid strobe. When no valid input is presented, the result register keeps its last value and the strobe drops. The unit sits in a media datapath as a one-cycle stage. Arithmetic, shifts and operand storage live elsewhere.

Top module: `lane_mix_unit`

## Requirements
- R1: While reset (`rstN` low, asynchronous) is active, `outValid` is 0 and `outData` is all zeros.
- R2: A valid input sampled at a rising edge makes `outValid` 1 with the matching `outData` after that same edge. `outValid` is 0 after any edge at which `inValid` was 0.
- R3: After an edge at which `inValid` was 0, `outData` keeps its previous value, whatever the code and operand inputs are.
- R4: Code 0x0 is signed narrowing of 16-bit lanes to bytes. Result byte k (k = 0..3) is A's 16-bit lane k clamped to -128..127, and byte 4+k is B's lane k clamped the same way. Values above the range become 0x7F and values below it become 0x80.
- R5: Code 0x1 is unsigned narrowing of 16-bit lanes to bytes, with the same placement as R4. Each source lane is read as signed and clamped to 0..255: negative values become 0x00 and values above 255 become 0xFF.
- R6: Code 0x2 is signed narrowing of 32-bit lanes to 16-bit words. Result word k (k = 0..1) is A's 32-bit lane k clamped to -32768..32767, and word 2+k is B's lane k. Overflow gives 0x7FFF and underflow gives 0x8000.
- R7: Codes 0x3 (lower half) and 0x4 (upper half) interleave bytes. Result byte 2k is byte k of A's selected 32-bit half, and byte 2k+1 is byte k of B's selected half, for k = 0..3.
- R8: Codes 0x5 (lower half) and 0x6 (upper half) interleave 16-bit words. Result word 2k is word k of A's selected half, and word 2k+1 is word k of B's selected half, for k = 0..1.
- R9: Codes 0x7 (lower half) and 0x8 (upper half) interleave 32-bit lanes. The result is {B half, A half}, with A's half in bits 31:0.
- R10: Codes 0x9 through 0xF give an all-zero result, with `outValid` asserted as for any valid input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands and code are valid this cycle |
| opCode | input | 4 | Operation select |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| outValid | output | 1 | Registered result is new this cycle |
| outData | output | 64 | Registered result |

## Verification
Every result is due exactly one rising edge after the valid input that produced it. The bench drives inputs on a falling edge and reads `outData` and `outValid` on the next falling edge, which falls after the single register stage has updated. Back-to-back inputs are read on consecutive falling edges. The hold and strobe-drop checks read at the falling edges after `inValid` has been low for one or more rising edges.

// File: rtl/lmu_pkg.sv
package lmu_pkg;

  typedef enum logic [3:0] {
    OP_NRW_S8   = 4'h0,
    OP_NRW_U8   = 4'h1,
    OP_NRW_S16  = 4'h2,
    OP_MIX8_LO  = 4'h3,
    OP_MIX8_HI  = 4'h4,
    OP_MIX16_LO = 4'h5,
    OP_MIX16_HI = 4'h6,
    OP_MIX32_LO = 4'h7,
    OP_MIX32_HI = 4'h8
  } lmu_op_e;

  typedef enum logic [2:0] {
    SEL_ZERO  = 3'd0,
    SEL_NRW8  = 3'd1,
    SEL_NRW16 = 3'd2,
    SEL_MIX8  = 3'd3,
    SEL_MIX16 = 3'd4,
    SEL_MIX32 = 3'd5
  } lmu_sel_e;

  typedef struct packed {
    logic     load;
    lmu_sel_e sel;
    logic     unsignedSat;
    logic     upperHalf;
  } lmu_ctrl_t;

endpackage

// File: rtl/lmu_ctrl.sv
module lmu_ctrl
  import lmu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [3:0] opCode,
  output lmu_ctrl_t  ctrl,
  output logic       outValid
);

  always_comb begin
    ctrl.load        = inValid;
    ctrl.sel         = SEL_ZERO;
    ctrl.unsignedSat = 1'b0;
    ctrl.upperHalf   = 1'b0;
    case (opCode)
      OP_NRW_S8:   ctrl.sel = SEL_NRW8;
      OP_NRW_U8: begin
        ctrl.sel         = SEL_NRW8;
        ctrl.unsignedSat = 1'b1;
      end
      OP_NRW_S16:  ctrl.sel = SEL_NRW16;
      OP_MIX8_LO:  ctrl.sel = SEL_MIX8;
      OP_MIX8_HI: begin
        ctrl.sel       = SEL_MIX8;
        ctrl.upperHalf = 1'b1;
      end
      OP_MIX16_LO: ctrl.sel = SEL_MIX16;
      OP_MIX16_HI: begin
        ctrl.sel       = SEL_MIX16;
        ctrl.upperHalf = 1'b1;
      end
      OP_MIX32_LO: ctrl.sel = SEL_MIX32;
      OP_MIX32_HI: begin
        ctrl.sel       = SEL_MIX32;
        ctrl.upperHalf = 1'b1;
      end
      default:     ctrl.sel = SEL_ZERO;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/lmu_datapath.sv
module lmu_datapath
  import lmu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  lmu_ctrl_t         ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] outData
);

  localparam int HALF_W   = DATA_W / 2;
  localparam int N_SRC16  = DATA_W / 16;
  localparam int N_SRC32  = DATA_W / 32;
  localparam int N_BYTE_H = HALF_W / 8;
  localparam int N_WORD_H = HALF_W / 16;

  function automatic logic [7:0] clampByte(input logic signed [15:0] v, input logic uns);
    if (uns) begin
      if (v < 16'sd0)        return 8'h00;
      else if (v > 16'sd255) return 8'hFF;
      else                   return v[7:0];
    end
    if (v > 16'sd127)       return 8'h7F;
    else if (v < -16'sd128) return 8'h80;
    else                    return v[7:0];
  endfunction

  function automatic logic [15:0] clampWord(input logic signed [31:0] v);
    if (v > 32'sd32767)       return 16'h7FFF;
    else if (v < -32'sd32768) return 16'h8000;
    else                      return v[15:0];
  endfunction

  logic [DATA_W-1:0] nrw8;
  logic [DATA_W-1:0] nrw16;
  logic [DATA_W-1:0] mix8;
  logic [DATA_W-1:0] mix16;
  logic [DATA_W-1:0] mix32;
  logic [HALF_W-1:0] halfA;
  logic [HALF_W-1:0] halfB;
  logic [DATA_W-1:0] nextData;

  assign halfA = ctrl.upperHalf ? opA[DATA_W-1:HALF_W] : opA[HALF_W-1:0];
  assign halfB = ctrl.upperHalf ? opB[DATA_W-1:HALF_W] : opB[HALF_W-1:0];

  for (genvar i = 0; i < N_SRC16; i++) begin : g_nrw8
    assign nrw8[8*i +: 8]           = clampByte(opA[16*i +: 16], ctrl.unsignedSat);
    assign nrw8[8*(N_SRC16+i) +: 8] = clampByte(opB[16*i +: 16], ctrl.unsignedSat);
  end

  for (genvar i = 0; i < N_SRC32; i++) begin : g_nrw16
    assign nrw16[16*i +: 16]           = clampWord(opA[32*i +: 32]);
    assign nrw16[16*(N_SRC32+i) +: 16] = clampWord(opB[32*i +: 32]);
  end

  for (genvar i = 0; i < N_BYTE_H; i++) begin : g_mix8
    assign mix8[16*i +: 8]     = halfA[8*i +: 8];
    assign mix8[16*i + 8 +: 8] = halfB[8*i +: 8];
  end

  for (genvar i = 0; i < N_WORD_H; i++) begin : g_mix16
    assign mix16[32*i +: 16]      = halfA[16*i +: 16];
    assign mix16[32*i + 16 +: 16] = halfB[16*i +: 16];
  end

  assign mix32 = {halfB, halfA};

  always_comb begin
    case (ctrl.sel)
      SEL_NRW8:  nextData = nrw8;
      SEL_NRW16: nextData = nrw16;
      SEL_MIX8:  nextData = mix8;
      SEL_MIX16: nextData = mix16;
      SEL_MIX32: nextData = mix32;
      default:   nextData = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          outData <= '0;
    else if (ctrl.load) outData <= nextData;
  end

endmodule

// File: rtl/lane_mix_unit.sv
module lane_mix_unit
  import lmu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);

  lmu_ctrl_t ctrl;

  lmu_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opCode   (opCode),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  lmu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .opA     (opA),
    .opB     (opB),
    .outData (outData)
  );

endmodule

// File: rtl/lmu_checker.sv
module lmu_checker #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [3:0]        opCode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              outValid,
  input logic [DATA_W-1:0] outData
);

  localparam int HALF_W = DATA_W / 2;

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (!outValid && outData == '0));

  // R2
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_valid_drops_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R3
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outData));

  // R4
  p_sat_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode == 4'h0 && $signed(opA[15:0]) > 16'sd127) |=> outData[7:0] == 8'h7F);

  // R5
  p_neg_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode == 4'h1 && opB[15]) |=> outData[HALF_W +: 8] == 8'h00);

  // R9
  p_dword_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode == 4'h7) |=> outData == {$past(opB[HALF_W-1:0]), $past(opA[HALF_W-1:0])});

  // R10
  p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode > 4'h8) |=> outData == '0);

endmodule

bind lane_mix_unit lmu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opCode   (opCode),
  .opA      (opA),
  .opB      (opB),
  .outValid (outValid),
  .outData  (outData)
);

// File: tb/lane_mix_unit_tb.sv
`timescale 1ns/1ps
module lane_mix_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  opCode = 4'h0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        outValid;
  logic [63:0] outData;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lane_mix_unit u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opCode   (opCode),
    .opA      (opA),
    .opB      (opB),
    .outValid (outValid),
    .outData  (outData)
  );

  function automatic logic [7:0] expByte(logic [15:0] x, bit uns);
    int v = int'($signed(x));
    if (uns) return (v < 0) ? 8'h00 : (v > 255) ? 8'hFF : x[7:0];
    return (v > 127) ? 8'h7F : (v < -128) ? 8'h80 : x[7:0];
  endfunction

  function automatic logic [15:0] expWord(logic [31:0] x);
    longint v = longint'($signed(x));
    return (v > 32767) ? 16'h7FFF : (v < -32768) ? 16'h8000 : x[15:0];
  endfunction

  function automatic logic [63:0] expected(logic [3:0] op, logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0;
    int base = (op == 4'h4 || op == 4'h6 || op == 4'h8) ? 32 : 0;
    case (op)
      4'h0, 4'h1: for (int k = 0; k < 4; k++) begin
        r[8*k +: 8]      = expByte(a[16*k +: 16], op == 4'h1);
        r[32 + 8*k +: 8] = expByte(b[16*k +: 16], op == 4'h1);
      end
      4'h2: for (int k = 0; k < 2; k++) begin
        r[16*k +: 16]      = expWord(a[32*k +: 32]);
        r[32 + 16*k +: 16] = expWord(b[32*k +: 32]);
      end
      4'h3, 4'h4: for (int k = 0; k < 4; k++) begin
        r[16*k +: 8]     = a[base + 8*k +: 8];
        r[16*k + 8 +: 8] = b[base + 8*k +: 8];
      end
      4'h5, 4'h6: for (int k = 0; k < 2; k++) begin
        r[32*k +: 16]      = a[base + 16*k +: 16];
        r[32*k + 16 +: 16] = b[base + 16*k +: 16];
      end
      4'h7, 4'h8: r = {b[base +: 32], a[base +: 32]};
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one valid operation, read the result one edge later.
  task automatic runOp(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] want, input string req);
    @(negedge clk);
    opCode = op; opA = a; opB = b; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({req, " R2 strobe"}, {63'd0, outValid}, 64'd1);
    check(req, outData, want);
    check({req, " model"}, outData, expected(op, a, b));
  endtask

  task automatic tReset();
    check("R1 valid in reset", {63'd0, outValid}, 64'd0);
    check("R1 data in reset", outData, 64'd0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R2 idle after reset", {63'd0, outValid}, 64'd0);
  endtask

  task automatic tNarrowSigned8();
    runOp(4'h0, 64'hFF80_007F_FF7F_0080, 64'h0001_FFFF_7FFF_8000,
          64'h01FF7F80_807F807F, "R4 signed byte narrow");
  endtask

  task automatic tNarrowUnsigned8();
    runOp(4'h1, 64'hFF80_007F_FF7F_0080, 64'h0001_FFFF_7FFF_8000,
          64'h0100FF00_007F0080, "R5 unsigned byte narrow");
  endtask

  task automatic tNarrowSigned16();
    runOp(4'h2, 64'hFFFF7FFF_00008000, 64'h00001234_FFFFFFFE,
          64'h1234FFFE_80007FFF, "R6 signed word narrow");
  endtask

  task automatic tInterleave();
    logic [63:0] a = 64'hA7A6A5A4A3A2A1A0;
    logic [63:0] b = 64'hB7B6B5B4B3B2B1B0;
    runOp(4'h3, a, b, 64'hB3A3B2A2B1A1B0A0, "R7 byte low");
    runOp(4'h4, a, b, 64'hB7A7B6A6B5A5B4A4, "R7 byte high");
    runOp(4'h5, a, b, 64'hB3B2A3A2B1B0A1A0, "R8 word low");
    runOp(4'h6, a, b, 64'hB7B6A7A6B5B4A5A4, "R8 word high");
    runOp(4'h7, a, b, 64'hB3B2B1B0A3A2A1A0, "R9 dword low");
    runOp(4'h8, a, b, 64'hB7B6B5B4A7A6A5A4, "R9 dword high");
  endtask

  task automatic tUnused();
    for (int c = 9; c < 16; c++)
      runOp(4'(c), 64'hDEADBEEF_01234567, 64'hFEDCBA98_76543210, 64'd0, "R10 unused code");
  endtask

  task automatic tHold();
    logic [63:0] held;
    runOp(4'h7, 64'h11112222_33334444, 64'h55556666_77778888,
          64'h77778888_33334444, "R9 before hold");
    held = outData;
    for (int k = 0; k < 3; k++) begin
      opCode = 4'(k + 3); opA = {32'h0, 32'(k) * 32'h01010101}; opB = ~opA;
      @(negedge clk);
      check("R3 data held", outData, held);
      check("R2 strobe low when idle", {63'd0, outValid}, 64'd0);
    end
  endtask

  task automatic tBackToBack();
    logic [63:0] a = 64'h0102030405060708;
    logic [63:0] b = 64'h8090A0B0C0D0E0F0;
    @(negedge clk);
    opCode = 4'h3; opA = a; opB = b; inValid = 1'b1;
    @(negedge clk);
    check("R2 first of pair", outData, expected(4'h3, a, b));
    opCode = 4'h6;
    @(negedge clk);
    inValid = 1'b0;
    check("R2 second of pair", outData, expected(4'h6, a, b));
    check("R2 strobe on second", {63'd0, outValid}, 64'd1);
    @(negedge clk);
    check("R2 strobe falls", {63'd0, outValid}, 64'd0);
  endtask

  task automatic tSweep();
    logic [63:0] s = 64'h9E3779B97F4A7C15;
    for (int n = 0; n < 45; n++) begin
      logic [63:0] a, b;
      s = {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
      a = s * 64'h2545F4914F6CDD1D;
      b = {s[31:0], s[63:32]} ^ 64'h00FF00FF80007FFF;
      runOp(4'(n % 9), a, b, expected(4'(n % 9), a, b), "R4 R5 R6 R7 R8 R9 sweep");
    end
  endtask

  task automatic tMidReset();
    runOp(4'h8, 64'hCAFEF00D_00000000, 64'h0BADBEEF_00000000,
          64'h0BADBEEF_CAFEF00D, "R9 before reset");
    #2 rstN = 1'b0;
    #1;
    check("R1 data cleared", outData, 64'd0);
    check("R1 valid cleared", {63'd0, outValid}, 64'd0);
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  endtask

  initial begin
    tReset();
    tNarrowSigned8();
    tNarrowUnsigned8();
    tNarrowSigned16();
    tInterleave();
    tUnused();
    tHold();
    tBackToBack();
    tSweep();
    tMidReset();
    tNarrowSigned8();
    finish();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish();
  end

endmodule